// File: doc/BRIEF.md
# Multi-Line Transmit Scanner with Memory-Resident Line Tables

This block serves up to sixteen asynchronous transmit lines and keeps almost none of their per-line state inside itself. Each line's output pointer and its remaining character count are held in two tables in external memory. The block reads and updates these tables through a single request/acknowledge memory port. A pending-output register has one bit per line. When a line has a set bit and an idle serialiser, the scanner reads that line's pointer and count, then fetches the addressed byte and hands it to the serialiser. It then writes the advanced pointer and count back to the tables. When the count reaches zero, the scanner clears the line's pending bit and raises the transmit-done flag, which can drive an interrupt.

Every line has its own serialiser. A serialiser sends a low start bit, then 5 to 8 data bits with the least significant bit first, then one or two high stop bits. Character length and the stop-bit count are global settings. A per-line break register forces the chosen lines low for as long as their bits are set. The block generates no baud rate: an external per-line tick marks each bit boundary.

The scanner FSM has six states. ST_SCAN picks the next eligible line in round-robin order and moves to ST_FADDR. ST_FADDR reads the pointer entry and moves to ST_FCNT. ST_FCNT reads the count entry. If the count is zero it completes the line and returns to ST_SCAN; otherwise it moves to ST_FCHAR. ST_FCHAR reads the character, loads the serialiser and moves to ST_WADDR. ST_WADDR writes the incremented pointer and moves to ST_WCNT. ST_WCNT writes the incremented count, completes the line if that count is zero, and returns to ST_SCAN.

Top module: `txscan_top`

## Requirements
- R1: After reset all txd lines are 1, the pending and break registers read 0, ctrl_q reads 0, tint_irq is 0 and mem_req is 0.
- R2: The pointer entry of line L is at byte address {base,8'h00}+2L and the count entry is at {base,8'h00}+8'h20+2L. A character is read from the word holding pointer p, at byte address {p[15:1],1'b0}. It is the low byte when p[0]=0 and the high byte when p[0]=1.
- R3: A frame is a 0 start bit, then 5+char_len data bits sent LSB first, then one stop bit of 1, or two when two_stop=1. Each bit lasts from one bit_tick of its line to the next. An idle line is 1.
- R4: After each character is fetched, the block writes pointer+1 to the line's pointer entry and count+1 (two's complement, 16 bits) to its count entry.
- R5: When a written-back count is 0, the line's pending bit is cleared and TINT (ctrl_q bit 15) is set. If a pending line's count already reads 0 at fetch time, the same happens with no character sent.
- R6: tint_irq equals TINT AND TIE (ctrl_q bit 12). A write to register select 0 loads TIE from data bit 12 and clears TINT when data bit 15 is 0.
- R7: Lines are considered in round-robin order, starting after the last line served. A line fetches only while its serialiser is idle, so with no ticks each pending line fetches exactly one character.
- R8: When software clears a line's pending bit, the character already being sent still completes, and no further character is fetched for that line.
- R9: While a line's break bit (register select 2) is set, its txd is 0. Register select 1 is the pending register and select 3 is the 8-bit table base.
- R10: Once mem_req is raised, it stays high with stable mem_addr, mem_we and mem_wdata until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_wr | input | 1 | Register write strobe |
| sw_sel | input | 2 | Register select: 0 ctrl, 1 pending, 2 break, 3 base |
| sw_wdata | input | 16 | Register write data |
| char_len | input | 2 | Data bits minus five |
| two_stop | input | 1 | 1 selects two stop bits |
| bit_tick | input | NLINES | Per-line bit boundary pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Access done, read data valid |
| mem_rdata | input | 16 | Read data |
| txd | output | NLINES | Serial outputs |
| act_q | output | NLINES | Pending-output register |
| brk_q | output | NLINES | Break register |
| ctrl_q | output | 16 | TINT at bit 15, TIE at bit 12 |
| tint_irq | output | 1 | Transmit interrupt request |

## Verification
A character's start bit appears on txd at the clock edge that accepts the character read. From then on, each txd bit changes only at an edge that samples that line's tick. The pointer and count write-backs follow as two further memory transactions. The pending bit clears and TINT sets one edge after the count write is acknowledged, and tint_irq follows TINT in the same cycle. Register writes and break take effect one edge after the strobe. The bench decodes txd at the falling edge of each tick cycle. It waits for these conditions through bounded polling loops and reads tables and registers only after the relevant transfer has settled. Memory latency is varied so that the request-hold rule is exercised.

// File: rtl/txscan_pkg.sv
package txscan_pkg;
    localparam int MEM_W    = 16;
    localparam int TIE_BIT  = 12;
    localparam int TINT_BIT = 15;
    localparam logic [7:0] CNT_TBL_OFS = 8'h20;

    typedef enum logic [2:0] {
        ST_SCAN  = 3'd0,
        ST_FADDR = 3'd1,
        ST_FCNT  = 3'd2,
        ST_FCHAR = 3'd3,
        ST_WADDR = 3'd4,
        ST_WCNT  = 3'd5
    } scan_st_t;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_ACT  = 2'd1,
        SEL_BRK  = 2'd2,
        SEL_BASE = 2'd3
    } reg_sel_t;
endpackage

// File: rtl/txscan_regs.sv
module txscan_regs
    import txscan_pkg::*;
#(
    parameter int NLINES = 16,
    localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr,
    input  logic [1:0]        sw_sel,
    input  logic [MEM_W-1:0]  sw_wdata,
    input  logic              done_pulse,
    input  logic [LW-1:0]     done_line,
    output logic [NLINES-1:0] act_q,
    output logic [NLINES-1:0] brk_q,
    output logic              tie_q,
    output logic              tint_q,
    output logic [7:0]        base_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q  <= '0;
            brk_q  <= '0;
            tie_q  <= 1'b0;
            tint_q <= 1'b0;
            base_q <= '0;
        end else begin
            if (sw_wr) begin
                unique case (reg_sel_t'(sw_sel))
                    SEL_CTRL: begin
                        tie_q  <= sw_wdata[TIE_BIT];
                        tint_q <= tint_q & sw_wdata[TINT_BIT];
                    end
                    SEL_ACT:  act_q  <= sw_wdata[NLINES-1:0];
                    SEL_BRK:  brk_q  <= sw_wdata[NLINES-1:0];
                    SEL_BASE: base_q <= sw_wdata[7:0];
                endcase
            end
            if (done_pulse) begin
                act_q[done_line] <= 1'b0;
                tint_q           <= 1'b1;
            end
        end
    end

    // R5
    tint_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> (tint_q && !act_q[$past(done_line)]));

    // R6
    tint_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && sw_sel == SEL_CTRL && !sw_wdata[TINT_BIT] && !done_pulse) |=> !tint_q);
endmodule

// File: rtl/txscan_arb.sv
module txscan_arb #(
    parameter int NLINES = 16,
    localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic [LW-1:0]     rr_ptr,
    input  logic [NLINES-1:0] cand,
    output logic              pick_vld,
    output logic [LW-1:0]     pick_idx
);
    always_comb begin
        logic [LW:0] s;
        pick_vld = 1'b0;
        pick_idx = '0;
        for (int k = 0; k < NLINES; k++) begin
            s = {1'b0, rr_ptr} + (LW+1)'(k);
            if (s >= (LW+1)'(NLINES)) s = s - (LW+1)'(NLINES);
            if (!pick_vld && cand[s[LW-1:0]]) begin
                pick_vld = 1'b1;
                pick_idx = s[LW-1:0];
            end
        end
    end
endmodule

// File: rtl/txscan_ser.sv
module txscan_ser #(
    parameter int DW = 8,
    localparam int FW = DW + 3,
    localparam int CW = $clog2(FW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [DW-1:0] ch,
    input  logic [3:0]    nbits,
    input  logic          two_stop,
    output logic          line,
    output logic          busy
);
    logic [FW-1:0] sh;
    logic [FW-1:0] frame;
    logic [CW-1:0] left;

    always_comb begin
        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DW; i++) begin
            if (i < int'(nbits)) frame[i+1] = ch[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh   <= '1;
            left <= '0;
        end else if (load) begin
            sh   <= frame;
            left <= CW'(nbits) + CW'(two_stop ? 3 : 2);
        end else if (tick && left != '0) begin
            sh   <= {1'b1, sh[FW-1:1]};
            left <= left - 1'b1;
        end
    end

    assign busy = (left != '0);
    assign line = busy ? sh[0] : 1'b1;

    // R3
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!line && busy));
endmodule

// File: rtl/txscan_top.sv
module txscan_top
    import txscan_pkg::*;
#(
    parameter int NLINES = 16,
    parameter int CHAR_W = 8,
    localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr,
    input  logic [1:0]        sw_sel,
    input  logic [15:0]       sw_wdata,
    input  logic [1:0]        char_len,
    input  logic              two_stop,
    input  logic [NLINES-1:0] bit_tick,
    output logic              mem_req,
    output logic              mem_we,
    output logic [15:0]       mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [15:0]       mem_rdata,
    output logic [NLINES-1:0] txd,
    output logic [NLINES-1:0] act_q,
    output logic [NLINES-1:0] brk_q,
    output logic [15:0]       ctrl_q,
    output logic              tint_irq
);
    scan_st_t st, st_n;

    logic [LW-1:0]     cur, rr, cur_nx, pick_idx;
    logic              pick_vld;
    logic [MEM_W-1:0]  ptr, cnt, cnt_inc;
    logic [MEM_W-1:0]  tbl_base, addr_ent, cnt_ent;
    logic [NLINES-1:0] ser_load, ser_busy, ser_line;
    logic [CHAR_W-1:0] ch_sel;
    logic [3:0]        nbits;
    logic              done_pulse;
    logic              tie_q, tint_q;
    logic [7:0]        base_q;

    txscan_regs #(.NLINES(NLINES)) u_regs (
        .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_sel(sw_sel),
        .sw_wdata(sw_wdata), .done_pulse(done_pulse), .done_line(cur),
        .act_q(act_q), .brk_q(brk_q), .tie_q(tie_q), .tint_q(tint_q),
        .base_q(base_q)
    );

    txscan_arb #(.NLINES(NLINES)) u_arb (
        .rr_ptr(rr), .cand(act_q & ~ser_busy),
        .pick_vld(pick_vld), .pick_idx(pick_idx)
    );

    assign nbits  = 4'(5 + int'(char_len));
    assign ch_sel = ptr[0] ? CHAR_W'(mem_rdata[15:8]) : CHAR_W'(mem_rdata[7:0]);

    genvar g;
    generate
        for (g = 0; g < NLINES; g++) begin : g_line
            txscan_ser #(.DW(CHAR_W)) u_ser (
                .clk(clk), .rst_n(rst_n), .tick(bit_tick[g]),
                .load(ser_load[g]), .ch(ch_sel), .nbits(nbits),
                .two_stop(two_stop), .line(ser_line[g]), .busy(ser_busy[g])
            );
            assign txd[g] = brk_q[g] ? 1'b0 : ser_line[g];
        end
    endgenerate

    assign tbl_base = {base_q, 8'h00};
    assign addr_ent = tbl_base + {{(MEM_W-1-LW){1'b0}}, cur, 1'b0};
    assign cnt_ent  = addr_ent + {8'h00, CNT_TBL_OFS};
    assign cnt_inc  = cnt + 1'b1;
    assign cur_nx   = (cur == LW'(NLINES-1)) ? '0 : cur + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_SCAN;
        else        st <= st_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= '0;
            rr  <= '0;
            ptr <= '0;
            cnt <= '0;
        end else begin
            if (st == ST_SCAN && pick_vld) cur <= pick_idx;
            if (st == ST_FADDR && mem_ack) ptr <= mem_rdata;
            if (st == ST_FCNT && mem_ack)  cnt <= mem_rdata;
            if (st_n == ST_SCAN && st != ST_SCAN) rr <= cur_nx;
        end
    end

    always_comb begin
        st_n       = st;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        ser_load   = '0;
        done_pulse = 1'b0;
        unique case (st)
            ST_SCAN: begin
                if (pick_vld) st_n = ST_FADDR;
            end
            ST_FADDR: begin
                mem_req  = 1'b1;
                mem_addr = addr_ent;
                if (mem_ack) st_n = ST_FCNT;
            end
            ST_FCNT: begin
                mem_req  = 1'b1;
                mem_addr = cnt_ent;
                if (mem_ack) begin
                    if (mem_rdata == '0) begin
                        done_pulse = 1'b1;
                        st_n       = ST_SCAN;
                    end else begin
                        st_n = ST_FCHAR;
                    end
                end
            end
            ST_FCHAR: begin
                mem_req  = 1'b1;
                mem_addr = {ptr[15:1], 1'b0};
                if (mem_ack) begin
                    ser_load[cur] = 1'b1;
                    st_n          = ST_WADDR;
                end
            end
            ST_WADDR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = addr_ent;
                mem_wdata = ptr + 1'b1;
                if (mem_ack) st_n = ST_WCNT;
            end
            ST_WCNT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cnt_ent;
                mem_wdata = cnt_inc;
                if (mem_ack) begin
                    if (cnt_inc == '0) done_pulse = 1'b1;
                    st_n = ST_SCAN;
                end
            end
            default: st_n = ST_SCAN;
        endcase
    end

    assign ctrl_q   = {tint_q, 2'b00, tie_q, 12'h000};
    assign tint_irq = tint_q & tie_q;

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R7
    load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ser_load) |-> ($onehot0(ser_load) && !(|(ser_load & ser_busy))));
endmodule

// File: tb/txscan_top_bench.sv
module txscan_top_bench;
    localparam int N  = 4;
    localparam int TP = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_wr = 1'b0;
    logic [1:0]  sw_sel = '0;
    logic [15:0] sw_wdata = '0;
    logic [1:0]  char_len = '0;
    logic        two_stop = 1'b0;
    logic [N-1:0] bit_tick;
    logic        mem_req, mem_we, mem_ack;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic [N-1:0] txd, act_q, brk_q;
    logic [15:0] ctrl_q;
    logic        tint_irq;

    txscan_top #(.NLINES(N)) u_txscan_top (
        .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_sel(sw_sel),
        .sw_wdata(sw_wdata), .char_len(char_len), .two_stop(two_stop),
        .bit_tick(bit_tick), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .txd(txd), .act_q(act_q), .brk_q(brk_q),
        .ctrl_q(ctrl_q), .tint_irq(tint_irq)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    bit done_rep = 0;

    task automatic report();
        if (!done_rep) begin
            done_rep = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            report();
        end
    end

    // memory model with variable latency
    logic [15:0] mem [0:255];
    int lat = 1, wcnt = 0;
    int order_log [0:31];
    int order_n = 0, char_reads = 0, hold_viol = 0;
    logic [15:0] last_addr;
    logic        last_wait = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            wcnt    <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            wcnt    <= 0;
        end else if (mem_req) begin
            if (last_wait && mem_addr != last_addr) hold_viol <= hold_viol + 1;
            if (wcnt >= lat - 1) begin
                mem_ack <= 1'b1;
                wcnt    <= 0;
                if (mem_we) mem[mem_addr[8:1]] <= mem_wdata;
                else begin
                    mem_rdata <= mem[mem_addr[8:1]];
                    if (mem_addr < 16'h0100) char_reads <= char_reads + 1;
                    if (mem_addr >= 16'h0120 && mem_addr < 16'h0128 && order_n < 32) begin
                        order_log[order_n] <= int'((mem_addr - 16'h0120) >> 1);
                        order_n <= order_n + 1;
                    end
                end
            end else wcnt <= wcnt + 1;
        end
        last_wait <= mem_req && !mem_ack;
        last_addr <= mem_addr;
    end

    // tick generator
    logic tick_en = 1'b1;
    logic tick_p = 1'b0;
    int   tcnt = 0;
    always @(posedge clk) begin
        tcnt   <= (tcnt == TP-1) ? 0 : tcnt + 1;
        tick_p <= (tcnt == TP-1) && tick_en;
    end
    assign bit_tick = {N{tick_p}};

    // per-line frame decoder, sampled at falling edge of tick cycles
    bit         in_fr [N];
    int         pos [N];
    logic [7:0] acc [N];
    logic [7:0] rx_q [N][16];
    int         rx_n [N];
    int         gap [N];
    int         st_tick [N];
    bit         started [N];
    int         stop_err = 0;
    int         tk = 0;

    task automatic clear_dec();
        for (int i = 0; i < N; i++) begin
            in_fr[i] = 0; pos[i] = 0; acc[i] = '0; rx_n[i] = 0;
            gap[i] = 0; started[i] = 0;
        end
        stop_err = 0;
    endtask

    always @(negedge clk) begin
        if (bit_tick[0]) begin
            for (int i = 0; i < N; i++) begin
                if (!in_fr[i]) begin
                    if (txd[i] == 1'b0 && !brk_q[i]) begin
                        in_fr[i] = 1; pos[i] = 0; acc[i] = '0;
                        if (started[i]) gap[i] = tk - st_tick[i];
                        st_tick[i] = tk; started[i] = 1;
                    end
                end else if (pos[i] < 5 + int'(char_len)) begin
                    acc[i][pos[i]] = txd[i];
                    pos[i] = pos[i] + 1;
                end else begin
                    if (txd[i] != 1'b1) stop_err++;
                    if (rx_n[i] < 16) rx_q[i][rx_n[i]] = acc[i];
                    rx_n[i] = rx_n[i] + 1;
                    in_fr[i] = 0;
                end
            end
            tk++;
        end
    end

    task automatic sw_write(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        sw_wr = 1'b1; sw_sel = sel; sw_wdata = d;
        @(negedge clk);
        sw_wr = 1'b0;
    endtask

    task automatic put_byte(input int a, input logic [7:0] v);
        if (a % 2 == 1) mem[a/2][15:8] = v;
        else            mem[a/2][7:0]  = v;
    endtask

    function automatic logic [7:0] exp_char(input int k, input int j);
        return 8'(k * 37 + j * 91 + 5);
    endfunction

    task automatic wait_idle(input int maxc);
        for (int c = 0; c < maxc; c++) begin
            @(negedge clk);
            if (act_q == '0) break;
        end
    endtask

    task automatic setup_line(input int l, input int start, input int len);
        mem[(16'h0100 + 2*l)/2] = 16'(start);
        mem[(16'h0120 + 2*l)/2] = 16'(-len);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        clear_dec();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 txd", int'(txd), (1 << N) - 1);
        chk("R1 act", int'(act_q), 0);
        chk("R1 ctrl", int'(ctrl_q), 0);
        chk("R1 irq", int'(tint_irq), 0);
        chk("R1 req", int'(mem_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 txd after release", int'(txd), (1 << N) - 1);

        sw_write(2'd3, 16'h0001);
        sw_write(2'd0, 16'h1000);

        // sweep of char length, stop bits, line, latency (R2 R3 R4 R5 R6 R10)
        for (int k = 0; k < 8; k++) begin
            int l, start, nb, ns;
            l = k % N; start = 16*k + (k % 2);
            char_len = 2'(k / 2); two_stop = k[0];
            nb = 5 + k / 2; ns = 1 + (k % 2);
            lat = 1 + (k % 3);
            for (int j = 0; j < 3; j++) put_byte(start + j, exp_char(k, j));
            setup_line(l, start, 3);
            clear_dec();
            sw_write(2'd1, 16'(1 << l));
            wait_idle(4000);
            repeat ((nb + ns + 3) * TP) @(negedge clk);
            chk("R3 char count", rx_n[l], 3);
            for (int j = 0; j < 3; j++)
                chk("R2 R3 char value", int'(rx_q[l][j]), int'(exp_char(k, j)) & ((1 << nb) - 1));
            chk("R3 frame ticks", gap[l], 1 + nb + ns);
            chk("R3 stop bit", stop_err, 0);
            chk("R4 pointer", int'(mem[(16'h0100 + 2*l)/2]), start + 3);
            chk("R4 count", int'(mem[(16'h0120 + 2*l)/2]), 0);
            chk("R5 TINT", int'(ctrl_q[15]), 1);
            chk("R6 irq set", int'(tint_irq), 1);
            sw_write(2'd0, 16'h1000);
            chk("R6 TINT cleared", int'(ctrl_q), 16'h1000);
            chk("R6 irq cleared", int'(tint_irq), 0);
        end

        // R6: TIE off masks the interrupt
        sw_write(2'd0, 16'h0000);
        lat = 2;

        // R7: round robin and idle-only fetch with ticks stopped
        tick_en = 1'b0;
        repeat (2 * TP) @(negedge clk);
        for (int l = 0; l < N; l++) begin
            put_byte(16'h90 + 8*l, 8'(8'h30 + l));
            put_byte(16'h91 + 8*l, 8'(8'h50 + l));
            setup_line(l, 16'h90 + 8*l, 2);
        end
        clear_dec();
        order_n = 0; char_reads = 0;
        sw_write(2'd1, 16'h000F);
        repeat (300) @(negedge clk);
        chk("R7 fetches while busy", order_n, N);
        for (int l = 0; l < N; l++) chk("R7 order", order_log[l], l);
        chk("R7 chars read", char_reads, N);
        chk("R7 pending kept", int'(act_q), 16'h000F);
        chk("R4 count mid", int'(mem[(16'h0120 + 2)/2]), 16'hFFFF);
        tick_en = 1'b1;
        wait_idle(4000);
        repeat (15 * TP) @(negedge clk);
        for (int l = 0; l < N; l++) begin
            chk("R7 line chars", rx_n[l], 2);
            chk("R7 second char", int'(rx_q[l][1]), 8'h50 + l);
        end
        for (int l = 0; l < N; l++) chk("R7 second round order", order_log[N + l], l);
        chk("R6 irq masked", int'(tint_irq), 0);
        chk("R6 TINT still set", int'(ctrl_q[15]), 1);
        sw_write(2'd0, 16'h1000);

        // R5: zero count at fetch
        char_reads = 0;
        setup_line(2, 16'h20, 0);
        sw_write(2'd1, 16'h0004);
        repeat (60) @(negedge clk);
        chk("R5 zero pending", int'(act_q), 0);
        chk("R5 zero TINT", int'(ctrl_q[15]), 1);
        chk("R5 zero no char", char_reads, 0);
        chk("R5 zero txd idle", int'(txd[2]), 1);
        sw_write(2'd0, 16'h1000);

        // R8: abort after first start bit
        for (int j = 0; j < 10; j++) put_byte(16'hC0 + j, 8'(8'hE1 + j));
        setup_line(1, 16'hC0, 10);
        clear_dec();
        sw_write(2'd1, 16'h0002);
        for (int c = 0; c < 500; c++) begin
            @(negedge clk);
            if (txd[1] == 1'b0) break;
        end
        sw_write(2'd1, 16'h0000);
        repeat (40 * TP) @(negedge clk);
        chk("R8 one char", rx_n[1], 1);
        chk("R8 char value", int'(rx_q[1][0]), 8'hE1);
        chk("R8 pointer", int'(mem[(16'h0102)/2]), 16'hC1);
        chk("R8 count", int'(mem[(16'h0122)/2]), 16'hFFF7);
        chk("R8 no TINT", int'(ctrl_q[15]), 0);

        // R9: break
        sw_write(2'd2, 16'h0008);
        for (int c = 0; c < 5; c++) begin
            repeat (20) @(negedge clk);
            chk("R9 break low", int'(txd[3]), 0);
            chk("R9 other line idle", int'(txd[0]), 1);
        end
        chk("R9 break reg", int'(brk_q), 8);
        sw_write(2'd2, 16'h0000);
        chk("R9 break released", int'(txd[3]), 1);

        chk("R10 request hold", hold_viol, 0);
        report();
    end
endmodule